// File: doc/BRIEF.md
# Display Supply Rail Sequencer

This block steps the supply rails of a display power device through four states: powered down, standby, active with the mirror-array rails on, and active with the lamp rail on as well. A projector-enable pin, which may arrive from any clock domain, gates the whole machine. While that pin is low the block sits in its powered-down state. Its control bits are held at their defaults there, and its register port is shut.

Once the pin is high, the block raises the internal power enable and releases reset. It also opens a small register port for the host. The host sets an array-enable bit to bring up the three array rails, then sets a lamp-enable bit to add the lamp rail. Fault flags arrive already synchronous to the clock: a vector of per-supply undervoltage flags, a thermal shutdown flag and an input-undervoltage-lockout flag. Any fault drops the machine back to standby and clears the array-enable bit. A lockout-triggered entry into standby also keeps reset asserted.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0 and `state_code` is 2'b00.
- R2: `proj_en_in` passes through two synchronizing flops. The state moves from powered-down to standby on the third rising clock edge after the input rises. From any state it moves to powered-down on the third edge after the input falls.
- R3: In standby, `pwr_on` and `host_if_en` are 1 and all four rail enables are 0. In powered-down state, `pwr_on`, `host_if_en` and `reset_n_out` are 0.
- R4: If standby is entered while `flt_uvlo` is 1, `reset_n_out` stays 0 for as long as the block remains in standby. On any other standby entry it is 1. In both active states it is 1.
- R5: Standby moves to the first active state when the array-enable bit is 1 and no fault is present. That state drives `mir_rst_en`, `bias_en` and `offs_en` to 1 and `led_en` to 0.
- R6: The first active state moves to the second when the lamp-enable bit is 1. The second state adds `led_en` = 1 and returns to the first when the lamp bit is 0.
- R7: From either active state, the block returns to standby one edge after the array-enable bit is 0 or a fault is present. This holds unless the synchronized projector enable is low, in which case it goes to powered-down.
- R8: The fault condition is the OR of every bit of `flt_uv`, `flt_therm` and `flt_uvlo`. A fault clears the array-enable bit and leaves the lamp-enable bit unchanged.
- R9: A write (`wr_en` = 1) to address `CTRL_ADDR` loads array-enable from `wr_data[0]` and lamp-enable from `wr_data[1]`. A write to any other address has no effect. A write while powered down has no effect. Both bits are 0 in the powered-down state, including the cycle the projector enable is seen rising.
- R10: `state_code` reports 2'b00 for powered-down, 2'b01 for standby, 2'b10 for the first active state and 2'b11 for the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proj_en_in | input | 1 | Projector enable, asynchronous |
| flt_uv | input | UV_W | Per-supply undervoltage flags |
| flt_therm | input | 1 | Thermal shutdown flag |
| flt_uvlo | input | 1 | Input undervoltage lockout flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| mir_rst_en | output | 1 | Mirror reset rail enable |
| bias_en | output | 1 | Bias rail enable |
| offs_en | output | 1 | Offset rail enable |
| led_en | output | 1 | Lamp rail enable |
| pwr_on | output | 1 | Internal power enable |
| reset_n_out | output | 1 | Active-low reset to downstream logic |
| host_if_en | output | 1 | Register port open |
| state_code | output | 2 | Current state code |

## Verification
The properties assume that the fault flags and the write port are already synchronous to `clk`, and that only `proj_en_in` is asynchronous. They also assume that a fault seen in an active state is honoured on the very next edge, with no filtering. The random stimulus changes every input only at the falling edge. It holds faults to a few percent of cycles so that the active states are still reached often. It toggles the projector enable rarely enough that full power-up sequences complete between drops.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_STBY = 2'b01,
    ST_ACT1 = 2'b10,
    ST_ACT2 = 2'b11
  } pstate_t;

  typedef struct packed {
    logic mir_rst;
    logic bias;
    logic offs;
    logic led;
  } rails_t;

  localparam int ARRAY_BIT = 0;
  localparam int LAMP_BIT  = 1;

  function automatic rails_t rails_for(pstate_t s);
    rails_t r;
    r = '0;
    if (s == ST_ACT1 || s == ST_ACT2) begin
      r.mir_rst = 1'b1;
      r.bias    = 1'b1;
      r.offs    = 1'b1;
    end
    if (s == ST_ACT2) r.led = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign sync_out = chain[STAGES-1];
  assign rise     = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rs_ctrl_regs.sv
module rs_ctrl_regs #(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_default,
  input  logic              port_open,
  input  logic              fault,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              array_en,
  output logic              lamp_en
);
  import rail_seq_pkg::*;

  logic hit;
  logic arr_d, lamp_d;

  assign hit = wr_en && port_open && (wr_addr == CTRL_ADDR);

  always_comb begin
    arr_d  = array_en;
    lamp_d = lamp_en;
    if (hit) begin
      arr_d  = wr_data[ARRAY_BIT];
      lamp_d = wr_data[LAMP_BIT];
    end
    if (fault) arr_d = 1'b0;
    if (hold_default) begin
      arr_d  = 1'b0;
      lamp_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      array_en <= 1'b0;
      lamp_en  <= 1'b0;
    end else begin
      array_en <= arr_d;
      lamp_en  <= lamp_d;
    end
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   proj_on,
  input  logic                   fault,
  input  logic                   uvlo,
  input  logic                   array_en,
  input  logic                   lamp_en,
  output rail_seq_pkg::pstate_t  state_q,
  output rail_seq_pkg::rails_t   rails_q,
  output logic                   pwr_on_q,
  output logic                   reset_n_q,
  output logic                   if_en_q
);
  import rail_seq_pkg::*;

  pstate_t nxt;
  logic    hold_q, hold_d;

  always_comb begin
    nxt = state_q;
    if (!proj_on) begin
      nxt = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  nxt = ST_STBY;
        ST_STBY: if (array_en && !fault) nxt = ST_ACT1;
        ST_ACT1: begin
          if (fault || !array_en) nxt = ST_STBY;
          else if (lamp_en)       nxt = ST_ACT2;
        end
        ST_ACT2: begin
          if (fault || !array_en) nxt = ST_STBY;
          else if (!lamp_en)      nxt = ST_ACT1;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (nxt != ST_STBY)          hold_d = 1'b0;
    else if (state_q != ST_STBY) hold_d = uvlo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      hold_q    <= 1'b0;
      rails_q   <= '0;
      pwr_on_q  <= 1'b0;
      reset_n_q <= 1'b0;
      if_en_q   <= 1'b0;
    end else begin
      state_q   <= nxt;
      hold_q    <= hold_d;
      rails_q   <= rails_for(nxt);
      pwr_on_q  <= (nxt != ST_OFF);
      if_en_q   <= (nxt != ST_OFF);
      reset_n_q <= (nxt != ST_OFF) && !hold_d;
    end
  end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
  parameter int                UV_W        = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proj_en_in,
  input  logic [UV_W-1:0]   flt_uv,
  input  logic              flt_therm,
  input  logic              flt_uvlo,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mir_rst_en,
  output logic              bias_en,
  output logic              offs_en,
  output logic              led_en,
  output logic              pwr_on,
  output logic              reset_n_out,
  output logic              host_if_en,
  output logic [1:0]        state_code
);
  import rail_seq_pkg::*;

  logic    proj_s, proj_rise, fault_any;
  logic    arr_bit, lamp_bit;
  pstate_t st;
  rails_t  rails;

  assign fault_any = (|flt_uv) | flt_therm | flt_uvlo;

  rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (proj_en_in),
    .sync_out (proj_s),
    .rise     (proj_rise)
  );

  rs_ctrl_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .hold_default (st == ST_OFF || proj_rise),
    .port_open    (host_if_en),
    .fault        (fault_any),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .array_en     (arr_bit),
    .lamp_en      (lamp_bit)
  );

  rs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .proj_on   (proj_s),
    .fault     (fault_any),
    .uvlo      (flt_uvlo),
    .array_en  (arr_bit),
    .lamp_en   (lamp_bit),
    .state_q   (st),
    .rails_q   (rails),
    .pwr_on_q  (pwr_on),
    .reset_n_q (reset_n_out),
    .if_en_q   (host_if_en)
  );

  assign mir_rst_en = rails.mir_rst;
  assign bias_en    = rails.bias;
  assign offs_en    = rails.offs;
  assign led_en     = rails.led;
  assign state_code = st;
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int UV_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [UV_W-1:0] flt_uv,
  input logic            flt_therm,
  input logic            flt_uvlo,
  input logic            mir_rst_en,
  input logic            bias_en,
  input logic            offs_en,
  input logic            led_en,
  input logic            pwr_on,
  input logic            reset_n_out,
  input logic            host_if_en,
  input logic [1:0]      state_code
);
  logic flt;
  assign flt = (|flt_uv) | flt_therm | flt_uvlo;

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b00 |-> !pwr_on && !host_if_en && !reset_n_out &&
                            !mir_rst_en && !bias_en && !offs_en && !led_en);

  // R3
  stby_rails_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b01 |-> pwr_on && host_if_en &&
                            !mir_rst_en && !bias_en && !offs_en && !led_en);

  // R5
  act1_rails_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b10 |-> mir_rst_en && bias_en && offs_en && !led_en && reset_n_out);

  // R6
  lamp_only_act2_chk: assert property (@(posedge clk) disable iff (rst)
    led_en |-> state_code == 2'b11);

  // R6
  act2_entry_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b11 |-> $past(state_code) == 2'b10 || $past(state_code) == 2'b11);

  // R7
  fault_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code[1] && flt) |=> state_code == 2'b01 || state_code == 2'b00);

  // R5
  stby_fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b01 && flt) |=> state_code != 2'b10);

  // R2
  off_exit_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b00 |=> state_code == 2'b00 || state_code == 2'b01);

  // R4
  uvlo_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code[1] && flt_uvlo) |=> !reset_n_out);
endmodule

bind rail_seq_ctrl rail_seq_chk #(.UV_W(UV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flt_uv      (flt_uv),
  .flt_therm   (flt_therm),
  .flt_uvlo    (flt_uvlo),
  .mir_rst_en  (mir_rst_en),
  .bias_en     (bias_en),
  .offs_en     (offs_en),
  .led_en      (led_en),
  .pwr_on      (pwr_on),
  .reset_n_out (reset_n_out),
  .host_if_en  (host_if_en),
  .state_code  (state_code)
);

// File: tb/sim_rail_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rail_seq_ctrl;
  localparam int UV_W = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] CA = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proj_en_in = 1'b0;
  logic [UV_W-1:0] flt_uv = '0;
  logic flt_therm = 1'b0, flt_uvlo = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic mir_rst_en, bias_en, offs_en, led_en, pwr_on, reset_n_out, host_if_en;
  logic [1:0] state_code;

  int n_tests = 0, n_fail = 0, cyc_cnt = 0;

  always #10 clk = ~clk;

  rail_seq_ctrl #(.UV_W(UV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CA)) u0 (
    .clk(clk), .rst(rst), .proj_en_in(proj_en_in), .flt_uv(flt_uv),
    .flt_therm(flt_therm), .flt_uvlo(flt_uvlo), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mir_rst_en(mir_rst_en), .bias_en(bias_en), .offs_en(offs_en),
    .led_en(led_en), .pwr_on(pwr_on), .reset_n_out(reset_n_out),
    .host_if_en(host_if_en), .state_code(state_code));

  // reference model, built from the requirements
  logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_arr = 0, m_lamp = 0, m_hold = 0;
  logic [1:0] m_st = 2'b00;

  function automatic logic [1:0] next_state(logic [1:0] s, logic on, logic f,
                                            logic a, logic l);
    if (!on) return 2'b00;
    case (s)
      2'b00: return 2'b01;
      2'b01: return (a && !f) ? 2'b10 : 2'b01;
      2'b10: return (f || !a) ? 2'b01 : (l ? 2'b11 : 2'b10);
      default: return (f || !a) ? 2'b01 : (l ? 2'b11 : 2'b10);
    endcase
  endfunction

  task automatic model_step();
    logic f, rise, a_n, l_n;
    logic [1:0] s_n;
    f    = (|flt_uv) | flt_therm | flt_uvlo;
    rise = m_s2 & ~m_prev;
    s_n  = next_state(m_st, m_s2, f, m_arr, m_lamp);
    a_n = m_arr; l_n = m_lamp;
    if (wr_en && m_st != 2'b00 && wr_addr == CA) begin
      a_n = wr_data[0]; l_n = wr_data[1];
    end
    if (f) a_n = 1'b0;
    if (m_st == 2'b00 || rise) begin a_n = 1'b0; l_n = 1'b0; end
    if (s_n != 2'b01) m_hold = 1'b0;
    else if (m_st != 2'b01) m_hold = flt_uvlo;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = proj_en_in;
    m_arr = a_n; m_lamp = l_n; m_st = s_n;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc_cnt);
    end
  endtask

  task automatic model_cmp();
    logic act;
    act = m_st[1];
    chk("R10", "state_code", state_code, m_st);
    chk("R5", "array rails", {mir_rst_en, bias_en, offs_en}, act ? 7 : 0);
    chk("R6", "led_en", led_en, m_st == 2'b11);
    chk("R3", "pwr_on/if_en", {pwr_on, host_if_en}, (m_st != 2'b00) ? 3 : 0);
    chk("R4", "reset_n_out", reset_n_out, (m_st != 2'b00) && !m_hold);
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst) model_step();
    @(negedge clk);
    cyc_cnt++;
    if (!rst) model_cmp();
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); cyc(); cyc();
    // R1: outputs held low during reset
    chk("R1", "outputs in reset", {mir_rst_en, bias_en, offs_en, led_en, pwr_on, reset_n_out, host_if_en, state_code}, 0);
    rst = 1'b0;
    cyc();
    chk("R1", "outputs after reset", {pwr_on, reset_n_out, host_if_en, state_code}, 0);

    proj_en_in = 1'b1;
    cyc(); cyc();
    chk("R2", "still off after two edges", state_code, 0);
    cyc();
    chk("R2", "standby on third edge", state_code, 1);
    chk("R3", "standby reset released", reset_n_out, 1);

    wr(CA, 8'h01);
    chk("R5", "no move on write edge", state_code, 1);
    cyc();
    chk("R5", "active1 reached", state_code, 2);
    wr(CA, 8'h03);
    cyc();
    chk("R6", "active2 reached", state_code, 3);

    flt_therm = 1'b1;
    cyc();
    chk("R7", "fault to standby", state_code, 1);
    chk("R7", "lamp off after fault", led_en, 0);
    flt_therm = 1'b0;
    cyc(); cyc();
    // R8: array bit was cleared by the fault, so no return to active
    chk("R8", "array bit cleared by fault", state_code, 1);
    wr(CA, 8'h01);
    cyc();
    chk("R8", "active1 after rewrite", state_code, 2);
    wr(CA, 8'h00);
    cyc();
    chk("R7", "array off to standby", state_code, 1);

    wr(CA, 8'h03);
    cyc(); cyc();
    chk("R6", "active2 via lamp bit", state_code, 3);
    wr(4'h5, 8'h00);
    cyc();
    chk("R9", "other address ignored", state_code, 3);
    wr(CA, 8'h01);
    cyc();
    chk("R6", "lamp cleared back to active1", state_code, 2);

    flt_uv = 4'b0100;
    cyc();
    chk("R8", "single uv bit is a fault", state_code, 1);
    flt_uv = '0;
    wr(CA, 8'h01);
    cyc();
    chk("R5", "active1 again", state_code, 2);

    flt_uvlo = 1'b1;
    cyc();
    chk("R4", "uvlo entry holds reset", {state_code, reset_n_out}, 2);
    flt_uvlo = 1'b0;
    cyc(); cyc();
    chk("R4", "reset still held in standby", reset_n_out, 0);

    proj_en_in = 1'b0;
    cyc(); cyc();
    chk("R2", "not off yet", state_code, 1);
    cyc();
    chk("R2", "off on third edge", state_code, 0);
    wr(CA, 8'h01);
    proj_en_in = 1'b1;
    cyc(); cyc(); cyc(); cyc(); cyc();
    chk("R9", "write while off ignored", state_code, 1);
    chk("R4", "normal entry releases reset", reset_n_out, 1);

    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 100 < 1) proj_en_in = ~proj_en_in;
      if (!proj_en_in && ($urandom % 4 == 0)) proj_en_in = 1'b1;
      flt_uv    = ($urandom % 100 < 2) ? UV_W'(1 << ($urandom % UV_W)) : '0;
      flt_therm = ($urandom % 100 < 2);
      flt_uvlo  = ($urandom % 100 < 2);
      wr_en     = ($urandom % 100 < 25);
      wr_addr   = ($urandom % 4 != 0) ? CA : ADDR_W'($urandom);
      wr_data   = DATA_W'($urandom);
      cyc();
    end
    wr_en = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule